// File: doc/BRIEF.md
# PDM Capture Receive FIFO and Interrupt Register Block

This block sits on the receive side of a multi-channel PDM capture peripheral. It receives finished samples, which are already decimated and filtered. Each sample arrives as a 24-bit value, a channel number of up to four channels and a valid strobe. The block tags each sample with its channel and stores it in a 16-entry receive FIFO. Software or a DMA engine drains the FIFO through a holding register on a simple 32-bit memory-mapped bus. Each read of that register pops one entry.

The block keeps six receive status flags and combines them with an interrupt mask into one level interrupt. The mask is managed through separate set and clear registers. Two of the flags are error flags that stay set until the status register is read. A programmable chunk threshold drives a DMA request, so a burst of that length can always be served. A software reset empties the FIFO and clears the error flags, and it leaves the configuration as it is.

Top module: `pdm_rx_regs`

## Requirements
- R1: After the reset input is released, the FIFO is empty. The status register reads 0x02, the mask reads 0, `irq_o` and `dma_req_o` are low, and the mode register reads 0x10000000 (chunk 1).
- R2: A read of offset 0x0C returns the oldest FIFO entry, with the sample in bits 23:0 and the channel index zero-extended in bits 31:24. The read pops that entry, so entries leave in arrival order.
- R3: The FIFO holds 16 entries. After 16 pushes, status bit 2 (full) is set. Sixteen holding-register reads then leave it empty, with status bit 1 set and bit 0 (ready, FIFO not empty) clear.
- R4: A sample that arrives while the FIFO is full, in a cycle with no pop, is discarded. It sets status bit 5 (overrun), which stays set until a status read.
- R5: A holding-register read while the FIFO is empty returns 0 and sets status bit 4 (underrun), which stays set until a status read.
- R6: A read of offset 0x20 returns the status and then clears bits 4 and 5. Bits 0 to 3 follow the FIFO level and are not affected by the read. An overrun in the same cycle as a status read stays set.
- R7: Writing 1s to offset 0x14 sets those mask bits and writing 1s to offset 0x18 clears them. Offset 0x1C returns the mask, and writes to 0x1C have no effect.
- R8: `irq_o` is high exactly when some status bit and the matching mask bit are both set.
- R9: Bits 31:28 of the mode register (offset 0x04) hold the chunk size, where 0 acts as 1. Status bit 3 and `dma_req_o` are high while the FIFO holds at least that many entries.
- R10: Writing a 1 to bit 0 of offset 0x00 empties the FIFO and clears bits 4 and 5, and it keeps the mask and the mode. Writing 0 there has no effect.
- R11: Offset 0x50 returns the 12-bit `VERSION` parameter in bits 11:0, with zeros above it. Offset 0x14 and unmapped offsets read as 0.
- R12: When the FIFO is full, a sample and a holding-register read in the same cycle are both accepted. No overrun is raised and the FIFO stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe from the filter chain |
| smp_data_i | input | DATA_W | Filtered sample |
| smp_chan_i | input | CH_W | Channel index of the sample |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt |
| dma_req_o | output | 1 | FIFO holds at least one chunk |

## Verification
The assertions check the rules that hold on every cycle:
- the FIFO level stays within bounds;
- the error flags are set when they should be and stay set until cleared;
- underrun reads return zero;
- the mask moves in response to set and clear writes;
- the interrupt stays quiet while the mask is zero;
- the DMA request never asserts on an empty FIFO;
- the software reset empties the FIFO and clears the error flags;
- a push and a pop in the same cycle on a full FIFO keep it full.

Only the directed scenarios can show the data itself. That covers the tag layout and arrival order of the holding words, that an overrunning sample really is discarded, the exact status words returned, the chunk thresholds including the zero encoding, the version value, and that writes to the read-only mask have no effect.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_HOLD = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_IDIS = 8'h18;
  localparam logic [7:0] OFS_IMSK = 8'h1C;
  localparam logic [7:0] OFS_ISTS = 8'h20;
  localparam logic [7:0] OFS_VER  = 8'h50;

  localparam int IRQ_N = 6;
  localparam int LVL_N = 4;
  localparam int STK_N = 2;
  // status bit positions
  localparam int ST_RDY = 0;
  localparam int ST_EMP = 1;
  localparam int ST_FUL = 2;
  localparam int ST_CHK = 3;
  localparam int ST_UDR = 4;
  localparam int ST_OVR = 5;

  localparam int CHUNK_LSB = 28;
  localparam int CHUNK_W   = 4;
endpackage

// File: rtl/pdm_rx_fifo.sv
module pdm_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 26,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  // a pop in the same cycle frees the slot for a push into a full FIFO
  assign do_push = push_i && (!full_o || do_pop);
  assign data_o  = mem[rd_ptr_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/pdm_rx_irq.sv
module pdm_rx_irq
  import pdm_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic [LVL_N-1:0] lvl_i,
  input  logic [STK_N-1:0] stk_set_i,
  input  logic             stk_clr_i,
  input  logic             en_wr_i,
  input  logic             dis_wr_i,
  input  logic [IRQ_N-1:0] bits_i,
  output logic [IRQ_N-1:0] status_o,
  output logic [IRQ_N-1:0] mask_o,
  output logic [STK_N-1:0] sticky_o,
  output logic             irq_o
);
  logic [STK_N-1:0] stk_q;
  logic [IRQ_N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stk_q <= '0;
    else if (srst_i)    stk_q <= '0;
    else                stk_q <= (stk_clr_i ? '0 : stk_q) | stk_set_i;
  end

  for (genvar b = 0; b < IRQ_N; b++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       mask_q[b] <= 1'b0;
      else if (en_wr_i && bits_i[b])     mask_q[b] <= 1'b1;
      else if (dis_wr_i && bits_i[b])    mask_q[b] <= 1'b0;
    end
  end

  assign status_o = {stk_q, lvl_i};
  assign mask_o   = mask_q;
  assign sticky_o = stk_q;
  assign irq_o    = |(status_o & mask_q);
endmodule

// File: rtl/pdm_rx_regs.sv
module pdm_rx_regs
  import pdm_rx_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          DATA_W  = 24,
  parameter int          CH_W    = 2,
  parameter int          ADDR_W  = 8,
  parameter logic [11:0] VERSION = 12'h1A3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [CH_W-1:0]   smp_chan_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  localparam int W     = CH_W + DATA_W;
  localparam int TAG_W = 32 - DATA_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic rd, wr;
  logic hit_ctrl, hit_mode, hit_hold, hit_ien, hit_idis, hit_imsk, hit_ists, hit_ver;
  logic srst, hold_rd, ists_rd;
  logic [W-1:0]  fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full, fifo_empty;
  logic [CHUNK_W-1:0] chunk_q, chunk_eff;
  logic          chunk_hit;
  logic [LVL_N-1:0] lvl;
  logic [STK_N-1:0] stk_set, sticky_q;
  logic [IRQ_N-1:0] status, mask_q;
  logic [31:0]   hold_word;
  logic          wdata_unused;

  assign rd = bus_sel_i && !bus_we_i;
  assign wr = bus_sel_i && bus_we_i;

  assign hit_ctrl = bus_addr_i == ADDR_W'(OFS_CTRL);
  assign hit_mode = bus_addr_i == ADDR_W'(OFS_MODE);
  assign hit_hold = bus_addr_i == ADDR_W'(OFS_HOLD);
  assign hit_ien  = bus_addr_i == ADDR_W'(OFS_IEN);
  assign hit_idis = bus_addr_i == ADDR_W'(OFS_IDIS);
  assign hit_imsk = bus_addr_i == ADDR_W'(OFS_IMSK);
  assign hit_ists = bus_addr_i == ADDR_W'(OFS_ISTS);
  assign hit_ver  = bus_addr_i == ADDR_W'(OFS_VER);

  assign srst    = wr && hit_ctrl && bus_wdata_i[0];
  assign hold_rd = rd && hit_hold;
  assign ists_rd = rd && hit_ists;

  pdm_rx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst),
    .push_i  (smp_valid_i),
    .pop_i   (hold_rd),
    .data_i  ({smp_chan_i, smp_data_i}),
    .data_o  (fifo_dout),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               chunk_q <= CHUNK_W'(1);
    else if (wr && hit_mode)   chunk_q <= bus_wdata_i[CHUNK_LSB +: CHUNK_W];
  end

  assign chunk_eff = (chunk_q == '0) ? CHUNK_W'(1) : chunk_q;
  assign chunk_hit = fifo_cnt >= CW'(chunk_eff);

  always_comb begin
    lvl         = '0;
    lvl[ST_RDY] = !fifo_empty;
    lvl[ST_EMP] = fifo_empty;
    lvl[ST_FUL] = fifo_full;
    lvl[ST_CHK] = chunk_hit;
  end

  assign stk_set[ST_UDR-LVL_N] = hold_rd && fifo_empty;
  assign stk_set[ST_OVR-LVL_N] = smp_valid_i && fifo_full && !hold_rd;

  pdm_rx_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .lvl_i     (lvl),
    .stk_set_i (stk_set),
    .stk_clr_i (ists_rd),
    .en_wr_i   (wr && hit_ien),
    .dis_wr_i  (wr && hit_idis),
    .bits_i    (bus_wdata_i[IRQ_N-1:0]),
    .status_o  (status),
    .mask_o    (mask_q),
    .sticky_o  (sticky_q),
    .irq_o     (irq_o)
  );

  assign hold_word = fifo_empty ? 32'h0 :
                     {TAG_W'(fifo_dout[W-1 -: CH_W]), fifo_dout[DATA_W-1:0]};

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (hit_mode)      bus_rdata_o[CHUNK_LSB +: CHUNK_W] = chunk_q;
      else if (hit_hold) bus_rdata_o = hold_word;
      else if (hit_imsk) bus_rdata_o[IRQ_N-1:0] = mask_q;
      else if (hit_ists) bus_rdata_o[IRQ_N-1:0] = status;
      else if (hit_ver)  bus_rdata_o[11:0] = VERSION;
    end
  end

  assign dma_req_o    = chunk_hit;
  assign wdata_unused = ^{bus_wdata_i[CHUNK_LSB-1:IRQ_N], hit_imsk && wr};
endmodule

// File: rtl/pdm_rx_checker.sv
module pdm_rx_checker
  import pdm_rx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              irq_o,
  input logic              dma_req_o,
  input logic [CW-1:0]     cnt_i,
  input logic [STK_N-1:0]  sticky_i,
  input logic [IRQ_N-1:0]  mask_i
);
  logic hold_rd, ists_rd, ien_wr, idis_wr, srst, udr, ovr;
  assign hold_rd = bus_sel_i && !bus_we_i && bus_addr_i == ADDR_W'(OFS_HOLD);
  assign ists_rd = bus_sel_i && !bus_we_i && bus_addr_i == ADDR_W'(OFS_ISTS);
  assign ien_wr  = bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_IEN);
  assign idis_wr = bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_IDIS);
  assign srst    = bus_sel_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_CTRL) && bus_wdata_i[0];
  assign udr     = sticky_i[ST_UDR-LVL_N];
  assign ovr     = sticky_i[ST_OVR-LVL_N];

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));
  p_ovr_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && cnt_i == CW'(DEPTH) && !hold_rd && !srst |=> ovr);
  p_ovr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr && !ists_rd && !srst |=> ovr);
  p_udr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rd && cnt_i == '0 |=> udr);
  p_udr_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rd && cnt_i == '0 |-> bus_rdata_o == 32'h0);
  p_ists_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ists_rd && !smp_valid_i |=> !ovr && !udr);
  p_ien_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_wr |=> (mask_i & $past(bus_wdata_i[IRQ_N-1:0])) == $past(bus_wdata_i[IRQ_N-1:0]));
  p_idis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idis_wr |=> (mask_i & $past(bus_wdata_i[IRQ_N-1:0])) == '0);
  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i == '0 |-> !irq_o);
  p_dma_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> cnt_i != '0);
  p_srst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> cnt_i == '0 && !ovr && !udr);
  p_full_pushpop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == CW'(DEPTH) && smp_valid_i && hold_rd |=> cnt_i == CW'(DEPTH) && $stable(ovr));
endmodule

bind pdm_rx_regs pdm_rx_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pdm_rx_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .dma_req_o   (dma_req_o),
  .cnt_i       (fifo_cnt),
  .sticky_i    (sticky_q),
  .mask_i      (mask_q)
);

// File: tb/pdm_rx_regs_bench.sv
module pdm_rx_regs_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic [1:0]  smp_chan = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, dma_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pdm_rx_regs u_pdm_rx_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .smp_chan_i(smp_chan),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .dma_req_o(dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // one bus access, optionally with a sample in the same cycle
  task automatic xfer(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic push, input logic [1:0] ch, input logic [23:0] s,
                      output logic [31:0] r);
    @(negedge clk);
    sel = 1'b1; we = w; addr = a; wdata = d;
    smp_valid = push; smp_chan = ch; smp_data = s;
    #(CLK_P/4);
    r = rdata;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    xfer(1'b0, a, 32'h0, 1'b0, 2'd0, 24'h0, r);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, 1'b0, 2'd0, 24'h0, r);
  endtask

  task automatic push(input logic [1:0] ch, input logic [23:0] s);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    logic [31:0] r;
    for (int i = 0; i < n; i++) rd(8'h0C, r);
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 dma", {31'b0, dma_req}, 32'h0);
    rd(8'h20, r); chk("R1 status", r, 32'h02);
    rd(8'h1C, r); chk("R1 mask", r, 32'h0);
    rd(8'h04, r); chk("R1 mode", r, 32'h1000_0000);
  endtask

  task automatic t_format;
    logic [31:0] r;
    push(2'd2, 24'hABCDEF);
    push(2'd3, 24'h123456);
    push(2'd0, 24'h000001);
    rd(8'h0C, r); chk("R2 word0", r, 32'h02AB_CDEF);
    rd(8'h0C, r); chk("R2 word1", r, 32'h0312_3456);
    rd(8'h0C, r); chk("R2 word2", r, 32'h0000_0001);
    rd(8'h20, r); chk("R2 empty after", r, 32'h02);
  endtask

  task automatic t_chunk;
    logic [31:0] r;
    wr(8'h04, 32'h4000_0000);
    rd(8'h04, r); chk("R9 mode readback", r, 32'h4000_0000);
    for (int i = 0; i < 3; i++) push(2'd1, 24'(i));
    chk("R9 dma below chunk", {31'b0, dma_req}, 32'h0);
    rd(8'h20, r); chk("R9 status 3 of 4", r, 32'h01);
    push(2'd1, 24'h3);
    chk("R9 dma at chunk", {31'b0, dma_req}, 32'h1);
    rd(8'h20, r); chk("R9 status 4 of 4", r, 32'h09);
    rd(8'h0C, r);
    chk("R9 dma after pop", {31'b0, dma_req}, 32'h0);
    wr(8'h04, 32'h0);
    chk("R9 chunk 0 acts as 1", {31'b0, dma_req}, 32'h1);
    drain(3);
    chk("R9 dma empty", {31'b0, dma_req}, 32'h0);
    wr(8'h04, 32'h1000_0000);
  endtask

  task automatic t_overrun;
    logic [31:0] r;
    for (int i = 0; i < 16; i++) push(2'(i % 4), 24'h100000 + 24'(i));
    rd(8'h20, r); chk("R3 full status", r, 32'h0D);
    push(2'd1, 24'hFFFFFF);
    rd(8'h20, r); chk("R4 overrun flagged", r, 32'h2D);
    rd(8'h20, r); chk("R6 sticky cleared by read", r, 32'h0D);
    for (int i = 0; i < 16; i++) begin
      rd(8'h0C, r);
      if (i == 0 || i == 15)
        chk("R4 dropped sample not stored", r, {6'b0, 2'(i % 4), 24'h100000 + 24'(i)});
    end
    rd(8'h20, r); chk("R3 drained after 16 reads", r, 32'h02);
  endtask

  task automatic t_underrun;
    logic [31:0] r;
    rd(8'h0C, r); chk("R5 empty read returns 0", r, 32'h0);
    rd(8'h20, r); chk("R5 underrun flagged", r, 32'h12);
    rd(8'h20, r); chk("R6 underrun cleared", r, 32'h02);
  endtask

  task automatic t_race;
    logic [31:0] r;
    for (int i = 0; i < 16; i++) push(2'd0, 24'(i));
    xfer(1'b0, 8'h20, 32'h0, 1'b1, 2'd2, 24'h777777, r);
    chk("R6 read returns pre-event", r, 32'h0D);
    rd(8'h20, r); chk("R6 event beats clear", r, 32'h2D);
    rd(8'h20, r); chk("R6 cleared next read", r, 32'h0D);
    drain(16);
  endtask

  task automatic t_mask;
    logic [31:0] r;
    wr(8'h14, 32'h02);
    rd(8'h1C, r); chk("R7 set empty mask", r, 32'h02);
    chk("R8 irq on empty", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h02);
    rd(8'h1C, r); chk("R7 cleared mask", r, 32'h0);
    chk("R8 irq off", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h30);
    chk("R8 no error yet", {31'b0, irq}, 32'h0);
    rd(8'h0C, r);
    chk("R8 irq on underrun", {31'b0, irq}, 32'h1);
    rd(8'h20, r); chk("R8 status seen", r, 32'h12);
    chk("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr(8'h1C, 32'h3F);
    rd(8'h1C, r); chk("R7 mask write ignored", r, 32'h30);
    wr(8'h18, 32'h3F);
    rd(8'h1C, r); chk("R7 mask cleared", r, 32'h0);
  endtask

  task automatic t_srst;
    logic [31:0] r;
    for (int i = 0; i < 5; i++) push(2'd3, 24'(i));
    wr(8'h00, 32'h0);
    rd(8'h20, r); chk("R10 write 0 no effect", r, 32'h09);
    wr(8'h14, 32'h01);
    chk("R8 irq on ready", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 12; i++) push(2'd3, 24'(i));
    wr(8'h00, 32'h1);
    rd(8'h20, r); chk("R10 flushed and cleared", r, 32'h02);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    chk("R10 dma low", {31'b0, dma_req}, 32'h0);
    rd(8'h1C, r); chk("R10 mask kept", r, 32'h01);
    rd(8'h04, r); chk("R10 mode kept", r, 32'h1000_0000);
    wr(8'h18, 32'h01);
  endtask

  task automatic t_version;
    logic [31:0] r;
    rd(8'h50, r); chk("R11 version", r, 32'h0000_01A3);
    rd(8'h44, r); chk("R11 unmapped", r, 32'h0);
    rd(8'h14, r); chk("R11 write-only reads 0", r, 32'h0);
  endtask

  task automatic t_full_pushpop;
    logic [31:0] r;
    for (int i = 0; i < 16; i++) push(2'd2, 24'h200000 + 24'(i));
    xfer(1'b0, 8'h0C, 32'h0, 1'b1, 2'd1, 24'hAAAAAA, r);
    chk("R12 pop returns head", r, 32'h0220_0000);
    rd(8'h20, r); chk("R12 full, no overrun", r, 32'h0D);
    for (int i = 0; i < 16; i++) begin
      rd(8'h0C, r);
      if (i == 14) chk("R12 old tail", r, 32'h0220_000F);
      if (i == 15) chk("R12 new sample kept", r, 32'h01AA_AAAA);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_format();
    t_chunk();
    t_overrun();
    t_underrun();
    t_race();
    t_mask();
    t_srst();
    t_version();
    t_full_pushpop();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule